// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a microcontroller bus and a parallel NOR-style flash array. Bus reads and writes go straight to it. It watches the writes for three-cycle unlock sequences and changes what later reads return. A read can return a byte of the array, a fixed device identifier, a per-sector protection flag, or an erase/program status byte. The array is modelled as a small register memory. A stub counter stands in for the duration of a program operation.

After reset, the block is in array-read mode. An unlocked query command puts it in a mode where three address bits pick between the identifier and the protection flag. That mode stays active until an unlocked reset command arrives. An unlocked program command arms a one-shot data write. The write goes into the array unless the selected sector is protected. While the stub counter runs, every read returns status and the bus writes are ignored. A side port preloads the protection register, with one bit for each sector.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (array read) and rdata_o is 00h. Reset clears every array byte to 00h.
- R2: In array mode (mode_o=0), a read at address A puts the array byte at index A[5:0] on rdata_o after the clock edge that samples re_i.
- R3: The writes AAh@555h, then 55h@AAAh, then 90h@555h set mode_o to 1 (query) after the third write.
- R4: In query mode, a read with A6=0, A1=0 and A0=1 returns ID_CODE (default E7h) when at least one sect_sel_i bit is set, and 00h when none is set. A read with A6=1 returns 00h.
- R5: In query mode, a read with A6=0, A1=1 and A0=0 returns 01h if the lowest-numbered active sect_sel_i bit names a protected sector, and 00h otherwise.
- R6: Query mode holds across any number of reads until the unlocked reset sequence (AAh@555h, 55h@AAAh, F0h@555h) arrives. That sequence sets mode_o to 0.
- R7: A write that does not match the next expected step of the unlock sequence sends the decoder back to idle and leaves mode_o unchanged. A fresh sequence that follows it is accepted.
- R8: After AAh@555h, 55h@AAAh and A0h@555h, the next write stores its data at its address and sets mode_o to 2 (status) for exactly BUSY_CYC (default 16) cycles. After that, mode_o is 0 and the array holds the data.
- R9: A read while mode_o=2 returns {~D[7], T, 000000b}, where D is the byte being programmed. T is 0 on the first status read and flips on each later status read.
- R10: Writes while mode_o=2 are ignored. An unlock-and-query sequence written during that time leaves mode_o at 0 once the program finishes.
- R11: A program data write whose lowest active sect_sel_i bit names a protected sector leaves the array unchanged and does not enter status mode.
- R12: A cycle with prot_we_i high loads prot_wdata_i into the protection register, one bit per sector. Later protection reads reflect the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (12) | Bus address |
| wdata_i | input | 8 | Bus write data |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe, one cycle per bus read |
| sect_sel_i | input | NSECT (8) | Sector select lines |
| prot_we_i | input | 1 | Protection register load strobe |
| prot_wdata_i | input | NSECT (8) | Protection register load value |
| rdata_o | output | 8 | Registered read data |
| mode_o | output | 2 | 0 array, 1 query, 2 status |

## Verification
The hardest state to reach is a bus write that lands while the program counter is still running. Reaching it takes a full unlock and program sequence, and then further writes must arrive inside the sixteen-cycle window. The bench does this by issuing two status reads and then a complete query sequence while the block is busy. It then checks after the busy window that the block came back to array mode and not to query mode. A protected-sector program write and a broken third unlock step are built in the same way from the ports, so the only evidence of these conditions is the returned mode and the array content.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {
    MD_ARRAY  = 2'd0,
    MD_QUERY  = 2'd1,
    MD_STATUS = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG
  } seq_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_QUERY,
    CMD_RESET,
    CMD_PROG
  } cmd_e;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UNL_A1 = 12'h555,
  parameter logic [ADDR_W-1:0] UNL_A2 = 12'hAAA,
  parameter logic [7:0] UNL_D1 = 8'hAA,
  parameter logic [7:0] UNL_D2 = 8'h55,
  parameter logic [7:0] OP_QUERY = 8'h90,
  parameter logic [7:0] OP_RESET = 8'hF0,
  parameter logic [7:0] OP_PROG = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output cmd_e              cmd_o,
  output logic              prog_stb_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    cmd_o      = CMD_NONE;
    prog_stb_o = 1'b0;
    if (we_i) begin
      unique case (st_q)
        SQ_IDLE: st_d = (addr_i == UNL_A1 && wdata_i == UNL_D1) ? SQ_UNL1 : SQ_IDLE;
        SQ_UNL1: st_d = (addr_i == UNL_A2 && wdata_i == UNL_D2) ? SQ_UNL2 : SQ_IDLE;
        SQ_UNL2: begin
          st_d = SQ_IDLE;
          if (addr_i == UNL_A1) begin
            if (wdata_i == OP_QUERY)      cmd_o = CMD_QUERY;
            else if (wdata_i == OP_RESET) cmd_o = CMD_RESET;
            else if (wdata_i == OP_PROG) begin
              cmd_o = CMD_PROG;
              st_d  = SQ_PROG;
            end
          end
        end
        SQ_PROG: begin
          prog_stb_o = 1'b1;
          st_d       = SQ_IDLE;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/fcd_busy.sv
module fcd_busy #(
  parameter int unsigned BUSY_CYC = 16,
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stat_rd_i,
  output logic busy_o,
  output logic tog_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;

  assign busy_o = (cnt_q != '0);
  assign tog_o  = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(BUSY_CYC);
      tog_q <= 1'b0;
    end else begin
      if (busy_o) cnt_q <= cnt_q - 1'b1;
      if (busy_o && stat_rd_i) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/fcd_store.sv
module fcd_store #(
  parameter int unsigned MEM_DEPTH = 64,
  parameter int unsigned NSECT = 8,
  localparam int unsigned IDX_W = $clog2(MEM_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             prot_we_i,
  input  logic [NSECT-1:0] prot_wdata_i,
  output logic [NSECT-1:0] prot_o
);
  logic [7:0]       mem_q [MEM_DEPTH];
  logic [NSECT-1:0] prot_q;

  assign rdata_o = mem_q[idx_i];
  assign prot_o  = prot_q;

  for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (wr_i && idx_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prot_q <= '0;
    else if (prot_we_i) prot_q <= prot_wdata_i;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NSECT     = 8,
  parameter int unsigned MEM_DEPTH = 64,
  parameter int unsigned BUSY_CYC  = 16,
  parameter logic [7:0]  ID_CODE   = 8'hE7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [NSECT-1:0]  sect_sel_i,
  input  logic              prot_we_i,
  input  logic [NSECT-1:0]  prot_wdata_i,
  output logic [7:0]        rdata_o,
  output logic [1:0]        mode_o
);
  localparam int unsigned IDX_W = $clog2(MEM_DEPTH);

  cmd_e             cmd;
  logic             prog_stb, prog_go, busy, tog, sel_prot;
  logic             query_q, pbit_q;
  logic [7:0]       mem_rd, rdata_q;
  logic [NSECT-1:0] prot;
  mode_e            mode;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i && !busy),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cmd_o     (cmd),
    .prog_stb_o(prog_stb)
  );

  fcd_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (prog_go),
    .stat_rd_i(re_i),
    .busy_o   (busy),
    .tog_o    (tog)
  );

  fcd_store #(.MEM_DEPTH(MEM_DEPTH), .NSECT(NSECT)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (prog_go),
    .idx_i       (addr_i[IDX_W-1:0]),
    .wdata_i     (wdata_i),
    .rdata_o     (mem_rd),
    .prot_we_i   (prot_we_i),
    .prot_wdata_i(prot_wdata_i),
    .prot_o      (prot)
  );

  // lowest-numbered active select decides
  always_comb begin
    sel_prot = 1'b0;
    for (int i = NSECT - 1; i >= 0; i--)
      if (sect_sel_i[i]) sel_prot = prot[i];
  end

  assign prog_go = prog_stb && !sel_prot;

  always_comb begin
    if (busy)         mode = MD_STATUS;
    else if (query_q) mode = MD_QUERY;
    else              mode = MD_ARRAY;
  end
  assign mode_o = mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      query_q <= 1'b0;
      pbit_q  <= 1'b0;
    end else begin
      if (cmd == CMD_QUERY)                         query_q <= 1'b1;
      else if (cmd == CMD_RESET || cmd == CMD_PROG) query_q <= 1'b0;
      if (prog_go) pbit_q <= wdata_i[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (re_i) begin
      unique case (mode)
        MD_QUERY: begin
          if (!addr_i[6] && addr_i[1:0] == 2'b01)
            rdata_q <= (|sect_sel_i) ? ID_CODE : 8'h00;
          else if (!addr_i[6] && addr_i[1:0] == 2'b10)
            rdata_q <= {7'b0, sel_prot};
          else
            rdata_q <= 8'h00;
        end
        MD_STATUS: rdata_q <= {~pbit_q, tog, 6'b0};
        default:   rdata_q <= mem_rd;
      endcase
    end
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NSECT    = 8,
  parameter int unsigned BUSY_CYC = 16,
  parameter logic [7:0]  ID_CODE  = 8'hE7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              re_i,
  input logic [NSECT-1:0]  sect_sel_i,
  input logic [7:0]        rdata_o,
  input logic [1:0]        mode_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (mode_o == 2'd2) run_q <= (run_q == CW'(BUSY_CYC + 1)) ? run_q : run_q + 1'b1;
    else                      run_q <= '0;
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (mode_o == 2'd0 && rdata_o == 8'h00));
  p_mode_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) mode_o != 2'd3);
  p_busy_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) run_q <= CW'(BUSY_CYC));
  p_id_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && re_i && !addr_i[6] && addr_i[1:0] == 2'b01 && |sect_sel_i) |=> rdata_o == ID_CODE);
  p_prot_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && re_i && !addr_i[6] && addr_i[1:0] == 2'b10) |=> rdata_o[7:1] == 7'd0);
  p_status_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && re_i) |=> rdata_o[5:0] == 6'd0);
  p_no_query_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |=> mode_o != 2'd1);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .NSECT(NSECT), .BUSY_CYC(BUSY_CYC), .ID_CODE(ID_CODE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .re_i      (re_i),
  .sect_sel_i(sect_sel_i),
  .rdata_o   (rdata_o),
  .mode_o    (mode_o)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  sect_sel_i = '0;
  logic        prot_we_i = 1'b0;
  logic [7:0]  prot_wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [1:0]  mode_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_cmd_decoder u0 (.*);

  // {kind, req, addr, data, sel, exp, mode}; kind 0 write, 1 read+check, 2 idle+mode check
  localparam int NV = 20;
  localparam logic [43:0] VEC [NV] = '{
    {2'd1, 4'd2, 12'h010, 8'h00, 8'h00, 8'h00, 2'd0}, // R2 array read
    {2'd0, 4'd3, 12'h555, 8'hAA, 8'h00, 8'h00, 2'd0},
    {2'd0, 4'd3, 12'hAAA, 8'h55, 8'h00, 8'h00, 2'd0},
    {2'd0, 4'd3, 12'h555, 8'h90, 8'h00, 8'h00, 2'd0},
    {2'd2, 4'd3, 12'h000, 8'h00, 8'h00, 8'h00, 2'd1}, // R3 query entered
    {2'd1, 4'd4, 12'h001, 8'h00, 8'h01, 8'hE7, 2'd1}, // R4 id
    {2'd1, 4'd4, 12'h001, 8'h00, 8'h00, 8'h00, 2'd1}, // R4 no select
    {2'd1, 4'd5, 12'h002, 8'h00, 8'h04, 8'h01, 2'd1}, // R5 protected
    {2'd1, 4'd5, 12'h002, 8'h00, 8'h02, 8'h00, 2'd1}, // R5 unprotected
    {2'd1, 4'd5, 12'h002, 8'h00, 8'h0C, 8'h01, 2'd1}, // R5 lowest select wins
    {2'd1, 4'd4, 12'h041, 8'h00, 8'h01, 8'h00, 2'd1}, // R4 A6 set
    {2'd1, 4'd6, 12'h001, 8'h00, 8'h80, 8'hE7, 2'd1}, // R6 repeated
    {2'd0, 4'd7, 12'h555, 8'hAA, 8'h00, 8'h00, 2'd1},
    {2'd0, 4'd7, 12'hAAA, 8'h00, 8'h00, 8'h00, 2'd1},
    {2'd1, 4'd7, 12'h001, 8'h00, 8'h01, 8'hE7, 2'd1}, // R7 broken, still query
    {2'd0, 4'd6, 12'h555, 8'hAA, 8'h00, 8'h00, 2'd1},
    {2'd0, 4'd6, 12'hAAA, 8'h55, 8'h00, 8'h00, 2'd1},
    {2'd0, 4'd6, 12'h555, 8'hF0, 8'h00, 8'h00, 2'd1},
    {2'd2, 4'd6, 12'h000, 8'h00, 8'h00, 8'h00, 2'd0}, // R6 reset cmd
    {2'd1, 4'd2, 12'h001, 8'h00, 8'h01, 8'h00, 2'd0}  // R2 array again
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d, logic [7:0] s);
    addr_i = a; wdata_i = d; sect_sel_i = s; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    #1;
  endtask

  task automatic rd(logic [11:0] a, logic [7:0] s);
    addr_i = a; sect_sel_i = s; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    #1;
  endtask

  task automatic unlock(logic [7:0] c);
    wr(12'h555, 8'hAA, 8'h00);
    wr(12'hAAA, 8'h55, 8'h00);
    wr(12'h555, c, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    #5;
    chk("R1 reset mode", {6'b0, mode_o}, 8'h00);
    chk("R1 reset rdata", rdata_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    prot_wdata_i = 8'h04; prot_we_i = 1'b1;   // R12 preload sector 2
    @(negedge clk_i);
    prot_we_i = 1'b0;
    #1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [3:0]  rq;
      logic [11:0] a;
      logic [7:0]  d, s, e;
      logic [1:0]  m;
      {k, rq, a, d, s, e, m} = VEC[i];
      if (k == 2'd0) wr(a, d, s);
      else if (k == 2'd1) begin
        rd(a, s);
        chk($sformatf("R%0d table row %0d data", rq, i), rdata_o, e);
        chk($sformatf("R%0d table row %0d mode", rq, i), {6'b0, mode_o}, {6'b0, m});
      end else begin
        @(negedge clk_i); #1;
        chk($sformatf("R%0d table row %0d mode", rq, i), {6'b0, mode_o}, {6'b0, m});
      end
    end

    // R8/R9/R10 program with status reads and writes while busy
    unlock(8'hA0);
    wr(12'h013, 8'h5A, 8'h01);
    chk("R8 status mode", {6'b0, mode_o}, 8'h02);
    rd(12'h013, 8'h01);
    chk("R9 first status", rdata_o, 8'h80);
    rd(12'h013, 8'h01);
    chk("R9 toggled status", rdata_o, 8'hC0);
    unlock(8'h90);
    repeat (16) @(negedge clk_i);
    #1;
    chk("R10 mode after busy", {6'b0, mode_o}, 8'h00);
    rd(12'h013, 8'h01);
    chk("R8 programmed byte", rdata_o, 8'h5A);

    // R8 busy duration
    unlock(8'hA0);
    wr(12'h020, 8'h33, 8'h01);
    n = 0;
    while (mode_o == 2'd2 && n < 40) begin
      n++;
      @(negedge clk_i); #1;
    end
    chk("R8 busy cycles", 8'(n), 8'd16);
    rd(12'h020, 8'h00);
    chk("R8 second byte", rdata_o, 8'h33);

    // R11 protected sector
    unlock(8'hA0);
    wr(12'h030, 8'h77, 8'h04);
    chk("R11 no status mode", {6'b0, mode_o}, 8'h00);
    rd(12'h030, 8'h00);
    chk("R11 array unchanged", rdata_o, 8'h00);

    // R7 broken third step, then restart
    unlock(8'h77);
    chk("R7 mode kept", {6'b0, mode_o}, 8'h00);
    wr(12'h555, 8'hAA, 8'h00);
    wr(12'hAAA, 8'h11, 8'h00);
    unlock(8'h90);
    chk("R7 restart accepted", {6'b0, mode_o}, 8'h01);

    // R12 reload protection
    prot_wdata_i = 8'h01; prot_we_i = 1'b1;
    @(negedge clk_i);
    prot_we_i = 1'b0;
    #1;
    rd(12'h002, 8'h04);
    chk("R12 sector2 cleared", rdata_o, 8'h00);
    rd(12'h002, 8'h01);
    chk("R12 sector0 set", rdata_o, 8'h01);

    // R1 asynchronous reset mid-query
    rd(12'h001, 8'h01);
    rst_ni = 1'b0;
    #1;
    chk("R1 async mode", {6'b0, mode_o}, 8'h00);
    chk("R1 async rdata", rdata_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    rd(12'h013, 8'h00);
    chk("R1 array cleared", rdata_o, 8'h00);

    finish_run();
  end
endmodule